// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block receives the device-to-host traffic of a PS/2 keyboard. The keyboard drives a clock line and a data line, and both are asynchronous to the system clock. Each line is first brought into the system clock domain by a short flop chain. It then passes through a filter, which moves its output only after the input has held a new level for a set number of system clocks.

The receiver samples the filtered data line on every falling edge of the filtered PS/2 clock. From these samples it assembles 11-bit frames: a start bit, eight data bits, an odd-parity bit and a stop bit. When a complete frame checks out, the block presents the data byte together with a strobe that lasts one system clock. A frame that fails the parity check, or that ends with a low stop bit, is read to its end and then dropped without any output.

There is no timeout. The receiver returns to step with the keyboard only through its idle state, which waits for a low start bit. It is meant to sit between a keyboard connector and a scan-code interpreter.

Top module: `ps2_frame_rx`

## Requirements
- R1: While the synchronous reset `rst` is high and on the first clock after it falls, `rxValid` is low. Reset returns the receiver to idle and sets both filtered lines low.
- R2: The data line is sampled only when the filtered PS/2 clock goes from high to low. Rising edges and steady levels of either line never advance the receiver.
- R3: A filtered line takes a new value only after its synchronized input has differed from the filtered value for FILTER_LEN consecutive system clocks (8 by default). A clock-line pulse of 5 system clocks therefore has no effect.
- R4: A frame consists of a low start bit, eight data bits, a parity bit and a stop bit. Data bits arrive least significant first, so the first data bit after the start bit appears in `rxByte[0]`.
- R5: In idle, a sample of the data line taken high leaves the receiver in idle. Only a low sample begins a frame.
- R6: Parity passes when the parity bit differs from the XOR of the eight data bits (odd parity). On a parity failure no byte is output, and the receiver still consumes the stop-bit slot before returning to idle.
- R7: A byte is output only if the stop bit is sampled high. After the stop-bit slot the receiver is idle whether or not a byte was output.
- R8: `rxValid` is high for exactly one system clock per accepted frame. It rises one clock after the falling PS/2 clock edge of the stop bit is seen in the filtered domain, and `rxByte` holds the byte during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2ClkIn | input | 1 | PS/2 clock line from the keyboard, asynchronous |
| ps2DataIn | input | 1 | PS/2 data line from the keyboard, asynchronous |
| rxByte | output | DATA_BITS | Received data byte, valid while rxValid is high |
| rxValid | output | 1 | One-clock strobe that marks an accepted byte |

## Verification
The bench builds the block with its defaults: two synchronizer stages, an 8-clock filter and 8 data bits. It drives the PS/2 clock with a 20-clock half period, long enough for every edge to pass the filter. At that rate one frame takes about 440 system clocks. This makes it possible to inject 5-clock clock-line glitches, to send high idle samples, to reset in mid-frame, and to send frames with a bad parity bit or a low stop bit, all while a behavioural model is compared against `rxValid` and `rxByte` on every clock.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_DATA   = 2'd1,
    RX_PARITY = 2'd2,
    RX_STOP   = 2'd3
  } rxState_e;

  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic clearBits;
    logic shiftBit;
    logic checkParity;
    logic emitByte;
  } rxCtl_t;

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = (FILTER_LEN > 1) ? $clog2(FILTER_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILTER_LEN - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic [CW-1:0]          holdCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= rawIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncChain <= '0;
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], rawIn};
      end
    end
  endgenerate

  assign syncOut = syncChain[SYNC_STAGES-1];

  // count consecutive clocks on which the synchronized level disagrees
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
      filtOut <= 1'b0;
    end else if (syncOut != filtOut) begin
      if (holdCnt == CNT_LAST) begin
        holdCnt <= '0;
        filtOut <= syncOut;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end else begin
      holdCnt <= '0;
    end
  end

  // R3: filtered level only ever moves towards the synchronized level
  p_filter_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(filtOut) |-> ($past(syncOut) == filtOut));

endmodule

// File: rtl/ps2_rx_control.sv
module ps2_rx_control
  import ps2_rx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clkLine,
  input  logic   dataLine,
  input  logic   lastBit,
  output rxCtl_t ctl
);
  rxState_e state, nextState;
  logic     clkPrev;
  logic     fallSeen;

  always_ff @(posedge clk) begin
    if (rst) clkPrev <= 1'b0;
    else     clkPrev <= clkLine;
  end

  assign fallSeen = clkPrev & ~clkLine;

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (fallSeen) begin
      unique case (state)
        RX_IDLE: begin
          if (!dataLine) begin
            ctl.clearBits = 1'b1;
            nextState     = RX_DATA;
          end
        end
        RX_DATA: begin
          ctl.shiftBit = 1'b1;
          if (lastBit) nextState = RX_PARITY;
        end
        RX_PARITY: begin
          ctl.checkParity = 1'b1;
          nextState       = RX_STOP;
        end
        RX_STOP: begin
          ctl.emitByte = dataLine;
          nextState    = RX_IDLE;
        end
        default: nextState = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= RX_IDLE;
    else     state <= nextState;
  end

  // R2: the state moves only on a filtered falling clock edge
  p_sample_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(state) |-> $past(fallSeen));

  // R5: a high sample in idle keeps the receiver idle
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && fallSeen && dataLine) |=> (state == RX_IDLE));

  // R7: the stop slot always leads back to idle
  p_stop_exit_r7: assert property (@(posedge clk) disable iff (rst)
    (state == RX_STOP && fallSeen) |=> (state == RX_IDLE));

endmodule

// File: rtl/ps2_rx_datapath.sv
module ps2_rx_datapath
  import ps2_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rxCtl_t               ctl,
  input  logic                 dataBit,
  output logic                 lastBit,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid
);
  localparam int BW = $clog2(DATA_BITS + 1);
  localparam logic [BW-1:0] LAST_IDX = BW'(DATA_BITS - 1);

  logic [DATA_BITS-1:0] shiftReg;
  logic [BW-1:0]        bitCount;
  logic                 parityOk;

  assign lastBit = (bitCount == LAST_IDX);

  // LSB-first: new bits enter at the top and walk down to bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      bitCount <= '0;
    end else if (ctl.clearBits) begin
      shiftReg <= '0;
      bitCount <= '0;
    end else if (ctl.shiftBit) begin
      shiftReg <= {dataBit, shiftReg[DATA_BITS-1:1]};
      bitCount <= bitCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  parityOk <= 1'b0;
    else if (ctl.clearBits)   parityOk <= 1'b0;
    else if (ctl.checkParity) parityOk <= dataBit ^ (^shiftReg);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxValid <= 1'b0;
      rxByte  <= '0;
    end else begin
      rxValid <= ctl.emitByte & parityOk;
      if (ctl.emitByte & parityOk) rxByte <= shiftReg;
    end
  end

  // R8: the strobe never lasts longer than one clock
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid);

  // R6: an output byte always follows a passed parity check
  p_parity_gate_r6: assert property (@(posedge clk) disable iff (rst)
    rxValid |-> $past(parityOk));

  // R4: never more data bits than a frame carries
  p_count_bound_r4: assert property (@(posedge clk) disable iff (rst)
    bitCount <= BW'(DATA_BITS));

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
  import ps2_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILTER_LEN  = 8,
  parameter int DATA_BITS   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ps2ClkIn,
  input  logic                 ps2DataIn,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid
);
  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] filtLines;
  rxCtl_t               ctl;
  logic                 lastBit;

  assign rawLines = {ps2DataIn, ps2ClkIn};

  generate
    for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
      ps2_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILTER_LEN (FILTER_LEN)
      ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .rawIn  (rawLines[li]),
        .filtOut(filtLines[li])
      );
    end
  endgenerate

  ps2_rx_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .clkLine (filtLines[0]),
    .dataLine(filtLines[1]),
    .lastBit (lastBit),
    .ctl     (ctl)
  );

  ps2_rx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .dataBit(filtLines[1]),
    .lastBit(lastBit),
    .rxByte (rxByte),
    .rxValid(rxValid)
  );

endmodule

// File: tb/tb_ps2_frame_rx.sv
`timescale 1ns/1ps
module tb_ps2_frame_rx;
  localparam int FL   = 8;
  localparam int HALF = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ps2Clk = 1'b1;
  logic       ps2Data = 1'b1;
  logic [7:0] rxByte;
  logic       rxValid;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ps2_frame_rx #(.SYNC_STAGES(2), .FILTER_LEN(FL), .DATA_BITS(8)) dut (
    .clk(clk), .rst(rst), .ps2ClkIn(ps2Clk), .ps2DataIn(ps2Data),
    .rxByte(rxByte), .rxValid(rxValid));

  // behavioural reference: index 0 = clock line, 1 = data line
  int  mS1[2], mS2[2], mF[2], mCnt[2];
  int  mPrev, mState, mShift, mBits, mPok, mValid, mByte;

  always @(posedge clk) begin
    int fall, dbit, pins[2];
    pins[0] = ps2Clk; pins[1] = ps2Data;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin mS1[k] = 0; mS2[k] = 0; mF[k] = 0; mCnt[k] = 0; end
      mPrev = 0; mState = 0; mShift = 0; mBits = 0; mPok = 0; mValid = 0; mByte = 0;
    end else begin
      fall = (mPrev == 1 && mF[0] == 0);
      dbit = mF[1];
      mValid = 0;
      if (fall) begin
        if (mState == 0) begin
          if (dbit == 0) begin mState = 1; mShift = 0; mBits = 0; mPok = 0; end
        end else if (mState == 1) begin
          mShift = (mShift >> 1) | (dbit << 7);
          mBits++;
          if (mBits == 8) mState = 2;
        end else if (mState == 2) begin
          mPok = (dbit != $countones(mShift[7:0]) % 2);
          mState = 3;
        end else begin
          if (dbit == 1 && mPok) begin mValid = 1; mByte = mShift; end
          mState = 0;
        end
      end
      mPrev = mF[0];
      for (int k = 0; k < 2; k++) begin
        if (mS2[k] != mF[k]) begin
          if (mCnt[k] == FL - 1) begin mF[k] = mS2[k]; mCnt[k] = 0; end
          else mCnt[k]++;
        end else mCnt[k] = 0;
        mS2[k] = mS1[k];
        mS1[k] = pins[k];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  byte unsigned gotQ[$];

  // cycle comparison against the model, sampled away from the edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rxValid === mValid[0], "R8 strobe vs model", rxValid, mValid);
      if (rxValid === 1'b1) begin
        chk(rxByte == mByte[7:0], "R4 byte vs model", rxByte, mByte);
        gotQ.push_back(rxByte);
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ps2Bit(input logic v);
    @(negedge clk) ps2Data = v;
    waitClk(HALF);
    ps2Clk = 1'b0;
    waitClk(HALF);
    ps2Clk = 1'b1;
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit badPar, input bit badStop);
    logic par;
    par = ~(^b) ^ badPar;
    ps2Bit(1'b0);
    for (int i = 0; i < 8; i++) ps2Bit(b[i]);
    ps2Bit(par);
    ps2Bit(badStop ? 1'b0 : 1'b1);
    @(negedge clk) ps2Data = 1'b1;
    waitClk(3 * HALF);
  endtask

  task automatic expectOne(input string tag, input int n, input logic [7:0] b);
    chk(gotQ.size() == n, tag, gotQ.size(), n);
    if (n == 1 && gotQ.size() == 1) chk(gotQ[0] == b, tag, gotQ[0], b);
    gotQ.delete();
  endtask

  initial begin
    waitClk(4);
    chk(rxValid === 1'b0, "R1 valid low in reset", rxValid, 0);
    @(negedge clk) rst = 1'b0;
    chk(rxValid === 1'b0, "R1 valid low after reset", rxValid, 0);
    waitClk(3 * HALF);
    gotQ.delete();

    // R4: LSB-first assembly over several patterns
    sendFrame(8'hA5, 0, 0); expectOne("R4 byte A5", 1, 8'hA5);
    sendFrame(8'h01, 0, 0); expectOne("R4 byte 01 first bit to bit0", 1, 8'h01);
    sendFrame(8'h80, 0, 0); expectOne("R4 byte 80", 1, 8'h80);
    sendFrame(8'h00, 0, 0); expectOne("R6 all-zero odd parity", 1, 8'h00);
    sendFrame(8'hFF, 0, 0); expectOne("R6 all-one odd parity", 1, 8'hFF);

    // R6: bad parity dropped, receiver recovers
    sendFrame(8'h3C, 1, 0); expectOne("R6 bad parity dropped", 0, 8'h00);
    sendFrame(8'h5A, 0, 0); expectOne("R6 recovers after bad parity", 1, 8'h5A);

    // R7: low stop bit dropped, receiver back in idle
    sendFrame(8'h77, 0, 1); expectOne("R7 low stop dropped", 0, 8'h00);
    sendFrame(8'h12, 0, 0); expectOne("R7 idle after low stop", 1, 8'h12);

    // R3: short clock glitch with data low must not start a frame
    @(negedge clk) ps2Data = 1'b0;
    waitClk(HALF);
    ps2Clk = 1'b0; waitClk(5); ps2Clk = 1'b1;
    waitClk(HALF);
    @(negedge clk) ps2Data = 1'b1;
    waitClk(2 * HALF);
    sendFrame(8'hC3, 0, 0); expectOne("R3 glitch ignored", 1, 8'hC3);

    // R5 and R2: high samples in idle, data toggling with clock high
    ps2Bit(1'b1); ps2Bit(1'b1);
    for (int i = 0; i < 4; i++) begin @(negedge clk) ps2Data = ~ps2Data; waitClk(HALF); end
    @(negedge clk) ps2Data = 1'b1;
    waitClk(2 * HALF);
    expectOne("R2 no sample without falling edge", 0, 8'h00);
    sendFrame(8'h96, 0, 0); expectOne("R5 idle stays idle on high", 1, 8'h96);

    // R1: reset in mid-frame returns to idle
    ps2Bit(1'b0); ps2Bit(1'b1); ps2Bit(1'b0); ps2Bit(1'b1);
    @(negedge clk) rst = 1'b1;
    waitClk(3);
    chk(rxValid === 1'b0, "R1 valid low in mid-frame reset", rxValid, 0);
    @(negedge clk) rst = 1'b0;
    waitClk(3 * HALF);
    sendFrame(8'h4E, 0, 0); expectOne("R1 clean frame after reset", 1, 8'h4E);

    waitClk(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule